// File: doc/BRIEF.md
# Programmable Tap Delay Line

This block is a cycle-accurate digital model of a programmable delay line. A single-bit input stream enters a long shift line, and a tap multiplexer picks the stage that reaches a registered, complementary output pair. The delay is set by a 10-bit tap code plus a step input that adds one full code span. A fixed two-cycle latency applies even at code zero. A disable input forces the true output low, and a cascade output pair carries a stored control bit so that several instances can be chained into a longer range.

The tap code and the cascade bit pass through a select latch. While the latch enable is low, the latch is open and follows the select inputs. While it is high, the latch holds the values sampled at the last clock edge at which it was still open. The step input is not latched. A change in the effective delay takes effect at once: the output moves to the newly chosen stage, and the shift line is not flushed.

Top module: `prog_tap_delay`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it rises, `q_o` is 0, `qn_o` is 1, `casc_o` is 0 and `cascn_o` is 1. Reset also clears every shift stage and the held select values, so that no stale 1 reaches the output.
- R2: With `setmax_i` low and the latch open, the value of `data_i` sampled at clock edge T appears on `q_o` after edge T+2+`sel_i`. At code 0 the delay is exactly 2 cycles, and at code 1 it is 3 cycles.
- R3: While `len_i` is low, the latch is open: a new `sel_i` or `casc_sel_i` value is used at the very next clock edge.
- R4: While `len_i` is high, changes on `sel_i` and `casc_sel_i` have no effect. The held values are those sampled at the last clock edge at which `len_i` was low, so a select change made in the same cycle that `len_i` rises is not captured.
- R5: `casc_o` equals the effective cascade bit (the live `casc_sel_i` while open, the held bit while closed), and `cascn_o` is its complement. Both follow without a clock.
- R6: `setmax_i` high adds 1024 cycles to the delay. Code 1023 with `setmax_i` low gives 1025 cycles, and code 0 with `setmax_i` high gives 1026 cycles, which is exactly one cycle more.
- R7: While `dis_i` is high, `q_o` is 0 and `qn_o` is 1 in the same cycle. The shift line keeps running, so the delayed stream returns intact once `dis_i` falls.
- R8: `qn_o` is always the complement of `q_o`.
- R9: After the effective delay changes from E1 to E2 at edge T, the output after edge T carries the data sampled at edge T-2-E2. The line is never flushed by the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Input stream to delay |
| len_i | input | 1 | Select latch enable: 0 open, 1 hold |
| sel_i | input | 10 | Tap code, bit 0 least significant, one cycle per step |
| casc_sel_i | input | 1 | Cascade control bit, latched like `sel_i` |
| setmax_i | input | 1 | Adds one full code span (1024 cycles) to the delay |
| dis_i | input | 1 | Forces `q_o` low when high |
| q_o | output | 1 | Delayed stream, true |
| qn_o | output | 1 | Delayed stream, complement |
| casc_o | output | 1 | Effective cascade bit |
| cascn_o | output | 1 | Complement of `casc_o` |

## Verification
The sharp case is the latch closing in the same cycle that the select code changes. The bench raises `len_i` and presents a new `sel_i` together between two edges. It then judges, from the output stream and `casc_o`, that the old code stayed in force. A second overlap is a select change that falls while `dis_i` is high. The bench checks that `q_o` stays low during the overlap and that, after release, the stream comes from the newly chosen stage with no flush. A behavioural history model judges every cycle.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int unsigned TDL_TAP_W = 10;
endpackage

// File: rtl/tdl_sel_latch.sv
module tdl_sel_latch #(
  parameter int unsigned W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         len_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] held_q;

  // open while len_i low; freezes at last edge seen with len_i low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= '0;
    else if (!len_i) held_q <= d_i;
  end

  assign eff_o = len_i ? held_q : d_i;

  AST_LATCH_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !len_i |=> held_q == $past(d_i)); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_i |=> $stable(held_q)); // R4
endmodule

// File: rtl/tdl_shift_line.sv
module tdl_shift_line #(
  parameter int unsigned LEN = 2048
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           din_i,
  output logic [LEN-1:0] line_o
);
  logic in_q;

  // input register: first cycle of the fixed latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= 1'b0;
    else         in_q <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_o <= '0;
    else         line_o <= {line_o[LEN-2:0], in_q};
  end

  AST_IN_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o[0] == $past(in_q)); // R2
  AST_LINE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o[LEN-1:1] == $past(line_o[LEN-2:0])); // R9
endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux #(
  parameter int unsigned IDX_W = 11,
  localparam int unsigned LEN  = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN-1:0]   line_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             dis_i,
  output logic             q_o,
  output logic             qn_o
);
  logic q_r;

  // output register: second cycle of the fixed latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= 1'b0;
    else         q_r <= line_i[idx_i];
  end

  assign q_o  = q_r & ~dis_i;
  assign qn_o = ~q_o;
endmodule

// File: rtl/prog_tap_delay.sv
module prog_tap_delay #(
  parameter int unsigned TAP_W = tdl_pkg::TDL_TAP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             len_i,
  input  logic [TAP_W-1:0] sel_i,
  input  logic             casc_sel_i,
  input  logic             setmax_i,
  input  logic             dis_i,
  output logic             q_o,
  output logic             qn_o,
  output logic             casc_o,
  output logic             cascn_o
);
  localparam int unsigned IDX_W    = TAP_W + 1;
  localparam int unsigned LINE_LEN = 1 << IDX_W;

  logic [TAP_W:0]    eff_sel;
  logic [IDX_W-1:0]  tap_idx;
  logic [LINE_LEN-1:0] line;

  tdl_sel_latch #(.W(TAP_W + 1)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .len_i (len_i),
    .d_i   ({casc_sel_i, sel_i}),
    .eff_o (eff_sel)
  );

  // setmax is the index MSB: adds exactly one full code span
  assign tap_idx = {setmax_i, eff_sel[TAP_W-1:0]};

  tdl_shift_line #(.LEN(LINE_LEN)) u_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i (data_i),
    .line_o(line)
  );

  tdl_tap_mux #(.IDX_W(IDX_W)) u_mux (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line),
    .idx_i (tap_idx),
    .dis_i (dis_i),
    .q_o   (q_o),
    .qn_o  (qn_o)
  );

  assign casc_o  = eff_sel[TAP_W];
  assign cascn_o = ~eff_sel[TAP_W];
endmodule

// File: tb/prog_tap_delay_bench.sv
module prog_tap_delay_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data = 1'b0, len = 1'b0, casc_sel = 1'b0, setmax = 1'b0, dis = 1'b0;
  logic [9:0] sel = '0;
  logic q, qn, casc, cascn;

  int tests = 0, fails = 0, n = 0;
  bit hist[$];
  logic [9:0] m_sel = '0;
  logic m_casc = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  prog_tap_delay u_prog_tap_delay (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .len_i(len), .sel_i(sel),
    .casc_sel_i(casc_sel), .setmax_i(setmax), .dis_i(dis),
    .q_o(q), .qn_o(qn), .casc_o(casc), .cascn_o(cascn)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, n);
    end
  endtask

  // one clock: model the edge with the inputs that were applied, then compare
  task automatic tick(string req);
    int eff, idx;
    bit exp_r, exp_q, exp_c;
    @(posedge clk);
    #1;
    n++;
    hist.push_back(data);
    eff = int'(len ? m_sel : sel) + (setmax ? 1024 : 0);
    idx = n - 2 - eff;
    exp_r = (idx >= 1) ? hist[idx] : 1'b0;
    if (!len) begin m_sel = sel; m_casc = casc_sel; end
    exp_q = exp_r & ~dis;
    exp_c = len ? m_casc : casc_sel;
    check({req, " q"}, q, exp_q);
    check("R8 qn", qn, !exp_q);
    check({"R5 casc ", req}, casc, exp_c);
    check("R5 cascn", cascn, !exp_c);
  endtask

  task automatic run(string req, int cycles);
    for (int i = 0; i < cycles; i++) begin
      tick(req);
      data = 1'($urandom);
    end
  endtask

  task automatic measure(string req, int expect_lat);
    int n0, lat;
    data = 1'b0;
    for (int i = 0; i < 2100; i++) tick(req);
    data = 1'b1;
    tick(req);
    n0 = n;
    data = 1'b0;
    lat = -1;
    for (int i = 0; i < 2200 && lat < 0; i++) begin
      tick(req);
      if (q) lat = n - n0;
    end
    check({req, " latency"}, lat, expect_lat);
  endtask

  initial begin
    hist.push_back(1'b0);
    repeat (3) @(posedge clk);
    #1;
    check("R1 q", q, 0);  check("R1 qn", qn, 1);
    check("R1 casc", casc, 0); check("R1 cascn", cascn, 1);
    rst_n = 1'b1;
    tick("R1");
    check("R1 q after release", q, 0);

    sel = 10'd0; run("R2 code0", 300);
    measure("R2 code0", 2);
    sel = 10'd1; run("R2 code1", 300);
    measure("R2 code1", 3);
    sel = 10'd1023; run("R2 code1023", 1500);
    measure("R6 full scale", 1025);
    sel = 10'd0; setmax = 1'b1;
    measure("R6 setmax step", 1026);
    run("R6 setmax stream", 1200);
    setmax = 1'b0; sel = 10'd1023; run("R9 setmax drop", 300);

    // latch closes while the select changes in the same cycle
    sel = 10'd5; casc_sel = 1'b1; run("R3 open", 50);
    len = 1'b1; sel = 10'd700; casc_sel = 1'b0;
    run("R4 closed", 200);
    check("R4 casc held", casc, 1);
    sel = 10'd33; casc_sel = 1'b0;
    run("R4 closed", 100);
    measure("R4 held delay", 7);
    len = 1'b0; run("R3 reopen", 100);
    check("R3 casc live", casc, 0);

    // disable overlapping a select change
    dis = 1'b1; #1; check("R7 q low same cycle", q, 0); check("R7 qn", qn, 1);
    run("R7 disabled", 40);
    sel = 10'd12; run("R7 disabled switch", 40);
    dis = 1'b0; run("R9 after disable", 200);
    for (int k = 0; k < 20; k++) begin
      sel = 10'($urandom_range(0, 60));
      dis = 1'($urandom_range(0, 3) == 0);
      run("R9 mid-stream", 30);
    end
    dis = 1'b0; run("R2 tail", 100);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule